// File: doc/BRIEF.md
# Flat-Table Address Translation Walker

This block turns 32-bit device virtual addresses into physical addresses through a single flat page table held in memory. The table has one 32-bit descriptor per 4 KB page, which gives 2^20 entries and 4 MB of table for the whole 4 GB space. A requester presents an address together with its port number and agent index on a valid/ready channel. The walker fetches the matching descriptor through a one-request read port and answers with a one-cycle response that carries either the translated address or a fault.

A descriptor is usable when its bit 1 is set. Its bits [31:12] give the physical page, and its bit 3 marks the page as non-secure. A fault sends the access to a 128-byte-aligned protect address instead of the translated one. On the first fault, the block records the status, the page-aligned faulting address and a packed requester identifier. It keeps that record until software clears it, and it raises an interrupt if the source is enabled. The fault record does not say whether the access was a read or a write.

Software uses a word-addressed register port. The register word index equals the byte offset divided by four: table base at 0x000, protect address at 0x214, interrupt control at 0x220, fault status at 0x224, fault address at 0x228 and fault identifier at 0x388.

Top module: `xlat_flat_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in flight. After a request is accepted, `req_ready` stays low until the cycle after the response pulse.
- R2: One cycle after acceptance, `mem_rd_en` is high for exactly one cycle. In that cycle `mem_rd_addr` equals the table base sampled at acceptance plus (iova >> 12) × 4, modulo 2^32.
- R3: When the descriptor has bit 1 set, `rsp_pa` = {descriptor[31:12], iova[11:0]}, `rsp_fault` = 0 and `rsp_nonsec` = descriptor bit 3.
- R4: When the descriptor has bit 1 clear, `rsp_fault` = 1, `rsp_nonsec` = 0 and `rsp_pa` equals the protect address.
- R5: Writes to the protect address register drop bits [6:0]; those bits read back as zero.
- R6: When a fault occurs and no fault is recorded, three registers are loaded. Fault status bit 0 becomes 1. The fault address becomes iova & 0xFFFFF000. The fault identifier gets the port in bits [11:8] and (6 − agent) in bits [15:13], with all other bits zero.
- R7: While a fault is recorded, a later fault does not change the fault status, the fault address or the fault identifier.
- R8: The interrupt control register stores and reads back eight source enables in bits [7:0]. `irq` is high exactly when a fault is recorded and enable bit 0 is set.
- R9: Writing interrupt control with bit 12 set clears the recorded fault. Bit 12 always reads back as 0, and a write with bit 12 clear leaves a recorded fault in place.
- R10: If a clear write and a new fault fall in the same cycle, the new fault is recorded and stays pending.
- R11: After reset, every register reads 0, `irq` is low and `req_ready` is high.
- R12: `rsp_valid` pulses for exactly one cycle per accepted request, in the cycle after `mem_rd_valid` is seen during the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_iova | input | 32 | Device virtual address |
| req_port | input | 4 | Requester port number |
| req_agent | input | 3 | Requester agent index, 0 to 6 |
| mem_rd_en | output | 1 | Descriptor read strobe |
| mem_rd_addr | output | 32 | Byte address of the descriptor |
| mem_rd_valid | input | 1 | Descriptor data returned |
| mem_rd_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_pa | output | 32 | Translated or redirected physical address |
| rsp_fault | output | 1 | Descriptor was not valid |
| rsp_nonsec | output | 1 | Page marked non-secure |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Fault interrupt |

## Verification
Fault capture and the software clear can land on the same clock edge. This happens when the descriptor for a faulting walk returns in the same cycle as the interrupt-control write with bit 12 set. The bench sets this up with a fixed one-cycle memory latency and places the clear write two falling edges after the request, while an older fault is still recorded. It then expects the newer fault address and identifier in the registers, with the interrupt still raised. The bench also tests the opposite cases on their own: a fault that arrives while one is already recorded must leave the record unchanged, and a clear with no fault arriving must drop the record.

// File: rtl/xw_pkg.sv
package xw_pkg;
   localparam int unsigned XW_RA_W = 10;
   localparam logic [XW_RA_W-1:0] RA_TBL_BASE = 10'h000;
   localparam logic [XW_RA_W-1:0] RA_PROTECT  = 10'h085;
   localparam logic [XW_RA_W-1:0] RA_INT_CTL  = 10'h088;
   localparam logic [XW_RA_W-1:0] RA_FLT_ST   = 10'h089;
   localparam logic [XW_RA_W-1:0] RA_FLT_VA   = 10'h08A;
   localparam logic [XW_RA_W-1:0] RA_FLT_ID   = 10'h0E2;
   localparam int unsigned CLR_BIT      = 12;
   localparam int unsigned ID_PORT_LSB  = 8;
   localparam int unsigned ID_AGENT_LSB = 13;

   typedef enum logic [1:0] {
      W_IDLE  = 2'd0,
      W_ISSUE = 2'd1,
      W_WAIT  = 2'd2,
      W_RESP  = 2'd3
   } walk_st_e;
endpackage

// File: rtl/xw_walk.sv
module xw_walk
   import xw_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned PAGE_SHIFT   = 12,
   parameter int unsigned PORT_W       = 4,
   parameter int unsigned AGENT_W      = 3,
   parameter int unsigned PROT_ALIGN   = 7,
   parameter int unsigned DESC_VLD_BIT = 1,
   parameter int unsigned DESC_NS_BIT  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_iova,
   input  logic [PORT_W-1:0]  req_port,
   input  logic [AGENT_W-1:0] req_agent,
   input  logic [ADDR_W-1:0]  tbl_base,
   input  logic [ADDR_W-1:0]  prot_base,
   output logic               mem_rd_en,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic               mem_rd_valid,
   input  logic [ADDR_W-1:0]  mem_rd_data,
   output logic               rsp_valid,
   output logic [ADDR_W-1:0]  rsp_pa,
   output logic               rsp_fault,
   output logic               rsp_nonsec,
   output logic               flt_evt,
   output logic [ADDR_W-1:0]  flt_va,
   output logic [PORT_W-1:0]  flt_port,
   output logic [AGENT_W-1:0] flt_agent
);
   localparam int unsigned VPN_W     = ADDR_W - PAGE_SHIFT;
   localparam int unsigned IDX_SHIFT = 2;

   walk_st_e st_q;
   logic [ADDR_W-1:0]  iova_q, addr_q, pa_q;
   logic [PORT_W-1:0]  port_q;
   logic [AGENT_W-1:0] agent_q;
   logic               fault_q, ns_q;
   logic               accept, desc_hit, desc_ok;
   logic [ADDR_W-1:0]  redirect_pa, xlat_pa, entry_addr;
   logic               unused_desc_low;

   assign accept     = req_valid && (st_q == W_IDLE);
   assign desc_hit   = (st_q == W_WAIT) && mem_rd_valid;
   assign desc_ok    = mem_rd_data[DESC_VLD_BIT];
   assign entry_addr = tbl_base + ADDR_W'({req_iova[ADDR_W-1:PAGE_SHIFT], {IDX_SHIFT{1'b0}}});
   assign xlat_pa    = {mem_rd_data[ADDR_W-1:PAGE_SHIFT], iova_q[PAGE_SHIFT-1:0]};
   assign unused_desc_low = ^mem_rd_data[PAGE_SHIFT-1:0];

   generate
      if (PROT_ALIGN > 0) begin : g_prot_aligned
         logic unused_prot_low;
         assign redirect_pa     = {prot_base[ADDR_W-1:PROT_ALIGN], {PROT_ALIGN{1'b0}}};
         assign unused_prot_low = ^prot_base[PROT_ALIGN-1:0];
      end else begin : g_prot_raw
         assign redirect_pa = prot_base;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= W_IDLE;
         iova_q  <= '0;
         addr_q  <= '0;
         port_q  <= '0;
         agent_q <= '0;
         pa_q    <= '0;
         fault_q <= 1'b0;
         ns_q    <= 1'b0;
      end else begin
         unique case (st_q)
            W_IDLE: if (accept) begin
               st_q    <= W_ISSUE;
               iova_q  <= req_iova;
               port_q  <= req_port;
               agent_q <= req_agent;
               addr_q  <= entry_addr;
            end
            W_ISSUE: st_q <= W_WAIT;
            W_WAIT: if (desc_hit) begin
               st_q    <= W_RESP;
               fault_q <= !desc_ok;
               ns_q    <= desc_ok && mem_rd_data[DESC_NS_BIT];
               pa_q    <= desc_ok ? xlat_pa : redirect_pa;
            end
            W_RESP: st_q <= W_IDLE;
            default: st_q <= W_IDLE;
         endcase
      end
   end

   assign req_ready   = (st_q == W_IDLE);
   assign mem_rd_en   = (st_q == W_ISSUE);
   assign mem_rd_addr = addr_q;
   assign rsp_valid   = (st_q == W_RESP);
   assign rsp_pa      = pa_q;
   assign rsp_fault   = fault_q;
   assign rsp_nonsec  = ns_q;
   assign flt_evt     = desc_hit && !desc_ok;
   assign flt_va      = {iova_q[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
   assign flt_port    = port_q;
   assign flt_agent   = agent_q;
endmodule

// File: rtl/xw_regs.sv
module xw_regs
   import xw_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned RA_W       = 10,
   parameter int unsigned PORT_W     = 4,
   parameter int unsigned AGENT_W    = 3,
   parameter int unsigned NSRC       = 8,
   parameter int unsigned PROT_ALIGN = 7,
   parameter int unsigned AGENT_TOP  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [RA_W-1:0]    reg_addr,
   input  logic [ADDR_W-1:0]  reg_wdata,
   output logic [ADDR_W-1:0]  reg_rdata,
   input  logic               flt_evt,
   input  logic [ADDR_W-1:0]  flt_va,
   input  logic [PORT_W-1:0]  flt_port,
   input  logic [AGENT_W-1:0] flt_agent,
   output logic [ADDR_W-1:0]  tbl_base,
   output logic [ADDR_W-1:0]  prot_base,
   output logic               fault_pending,
   output logic [ADDR_W-1:0]  fault_va,
   output logic [NSRC-1:0]    int_en,
   output logic               clr_req,
   output logic               irq
);
   localparam logic [ADDR_W-1:0] PROT_KEEP = ~ADDR_W'((64'd1 << PROT_ALIGN) - 64'd1);

   logic [ADDR_W-1:0] base_q, prot_q, fva_q, fid_q, id_pack;
   logic [NSRC-1:0]   en_q, src_pend;
   logic              pend_q, take_fault;

   always_comb begin
      id_pack = '0;
      id_pack[ID_AGENT_LSB +: AGENT_W] = AGENT_W'(AGENT_TOP) - flt_agent;
      id_pack[ID_PORT_LSB +: PORT_W]   = flt_port;
   end

   assign clr_req    = reg_we && (reg_addr == RA_INT_CTL) && reg_wdata[CLR_BIT];
   assign take_fault = flt_evt && (!pend_q || clr_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         prot_q <= '0;
         en_q   <= '0;
         pend_q <= 1'b0;
         fva_q  <= '0;
         fid_q  <= '0;
      end else begin
         if (reg_we) begin
            if (reg_addr == RA_TBL_BASE) base_q <= reg_wdata;
            if (reg_addr == RA_PROTECT)  prot_q <= reg_wdata & PROT_KEEP;
            if (reg_addr == RA_INT_CTL)  en_q   <= reg_wdata[NSRC-1:0];
         end
         if (take_fault) begin
            pend_q <= 1'b1;
            fva_q  <= flt_va;
            fid_q  <= id_pack;
         end else if (clr_req) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign src_pend = NSRC'(pend_q);

   always_comb begin
      unique case (reg_addr)
         RA_TBL_BASE: reg_rdata = base_q;
         RA_PROTECT:  reg_rdata = prot_q;
         RA_INT_CTL:  reg_rdata = ADDR_W'(en_q);
         RA_FLT_ST:   reg_rdata = ADDR_W'(src_pend);
         RA_FLT_VA:   reg_rdata = fva_q;
         RA_FLT_ID:   reg_rdata = fid_q;
         default:     reg_rdata = '0;
      endcase
   end

   assign tbl_base      = base_q;
   assign prot_base     = prot_q;
   assign fault_pending = pend_q;
   assign fault_va      = fva_q;
   assign int_en        = en_q;
   assign irq           = |(src_pend & en_q);
endmodule

// File: rtl/xlat_flat_walker.sv
module xlat_flat_walker
   import xw_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned PORT_W     = 4,
   parameter int unsigned AGENT_W    = 3,
   parameter int unsigned NSRC       = 8,
   parameter int unsigned PROT_ALIGN = 7,
   parameter int unsigned AGENT_TOP  = 6,
   parameter int unsigned RA_W       = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_iova,
   input  logic [PORT_W-1:0]  req_port,
   input  logic [AGENT_W-1:0] req_agent,
   output logic               mem_rd_en,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic               mem_rd_valid,
   input  logic [ADDR_W-1:0]  mem_rd_data,
   output logic               rsp_valid,
   output logic [ADDR_W-1:0]  rsp_pa,
   output logic               rsp_fault,
   output logic               rsp_nonsec,
   input  logic               reg_we,
   input  logic [RA_W-1:0]    reg_addr,
   input  logic [ADDR_W-1:0]  reg_wdata,
   output logic [ADDR_W-1:0]  reg_rdata,
   output logic               irq
);
   generate
      if (ADDR_W != 32) begin : g_bad_addr_w
         $error("xlat_flat_walker: address width must be 32");
      end
      if (PAGE_SHIFT != 12) begin : g_bad_page
         $error("xlat_flat_walker: only 4 KB pages are handled");
      end
      if (RA_W != XW_RA_W) begin : g_bad_ra_w
         $error("xlat_flat_walker: register index width must match package");
      end
      if (NSRC < 1 || NSRC > CLR_BIT) begin : g_bad_nsrc
         $error("xlat_flat_walker: source count must sit below the clear bit");
      end
      if (PORT_W > ID_AGENT_LSB - ID_PORT_LSB || AGENT_W + ID_AGENT_LSB > ADDR_W) begin : g_bad_id
         $error("xlat_flat_walker: identifier fields overlap");
      end
      if (PROT_ALIGN >= PAGE_SHIFT) begin : g_bad_prot
         $error("xlat_flat_walker: protect alignment too coarse");
      end
   endgenerate

   logic [ADDR_W-1:0]  tbl_base, prot_base, flt_va, fault_va;
   logic [PORT_W-1:0]  flt_port;
   logic [AGENT_W-1:0] flt_agent;
   logic [NSRC-1:0]    int_en;
   logic               flt_evt, fault_pending, clr_req;

   xw_walk #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PORT_W(PORT_W),
      .AGENT_W(AGENT_W), .PROT_ALIGN(PROT_ALIGN), .DESC_VLD_BIT(1), .DESC_NS_BIT(3)
   ) u_walk (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_iova(req_iova),
      .req_port(req_port), .req_agent(req_agent),
      .tbl_base(tbl_base), .prot_base(prot_base),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_nonsec(rsp_nonsec),
      .flt_evt(flt_evt), .flt_va(flt_va), .flt_port(flt_port), .flt_agent(flt_agent)
   );

   xw_regs #(
      .ADDR_W(ADDR_W), .RA_W(RA_W), .PORT_W(PORT_W), .AGENT_W(AGENT_W),
      .NSRC(NSRC), .PROT_ALIGN(PROT_ALIGN), .AGENT_TOP(AGENT_TOP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .flt_evt(flt_evt), .flt_va(flt_va), .flt_port(flt_port), .flt_agent(flt_agent),
      .tbl_base(tbl_base), .prot_base(prot_base),
      .fault_pending(fault_pending), .fault_va(fault_va), .int_en(int_en),
      .clr_req(clr_req), .irq(irq)
   );
endmodule

// File: rtl/xw_checker.sv
module xw_checker #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned PROT_ALIGN = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              mem_rd_en,
   input logic              rsp_valid,
   input logic              rsp_fault,
   input logic [ADDR_W-1:0] rsp_pa,
   input logic              irq,
   input logic              flt_evt,
   input logic              clr_req,
   input logic              fault_pending,
   input logic [ADDR_W-1:0] fault_va,
   input logic              int_en0
);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << PROT_ALIGN) - 64'd1);

   a_r1_busy_while_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> !req_ready);

   a_r1_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && mem_rd_en));

   a_r2_single_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));

   a_r4_redirect_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> ((rsp_pa & LOW_MASK) == '0));

   a_r7_record_held: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_pending && !clr_req) |=> (fault_pending && $stable(fault_va)));

   a_r10_collision_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_evt && clr_req) |=> fault_pending);

   a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !flt_evt) |=> !fault_pending);

   a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (fault_pending && int_en0));
endmodule

bind xlat_flat_walker xw_checker #(.ADDR_W(ADDR_W), .PROT_ALIGN(PROT_ALIGN)) u_xw_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .mem_rd_en(mem_rd_en), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
   .irq(irq), .flt_evt(flt_evt), .clr_req(clr_req), .fault_pending(fault_pending),
   .fault_va(fault_va), .int_en0(int_en[0])
);

// File: tb/xlat_flat_walker_tb_top.sv
module xlat_flat_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_iova = '0;
   logic [3:0]  req_port = '0;
   logic [2:0]  req_agent = '0;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_data;
   logic        rsp_valid;
   logic [31:0] rsp_pa;
   logic        rsp_fault;
   logic        rsp_nonsec;
   logic        reg_we = 1'b0;
   logic [9:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   int lat_cfg = 1;
   bit done = 1'b0;
   logic [31:0] dmem [logic [31:0]];

   always #5 clk = ~clk;

   xlat_flat_walker dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_iova(req_iova),
      .req_port(req_port), .req_agent(req_agent),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_nonsec(rsp_nonsec),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model: phase counter and expected register state, updated per edge
   int          m_ph;
   logic [31:0] m_iova, m_addr, m_base, m_prot, m_pa;
   logic [7:0]  m_en;
   logic        m_pend, m_fault, m_ns;

   always @(posedge clk) begin
      logic clr_v;
      logic flt_v;
      if (!rst_n) begin
         m_ph <= 0; m_iova <= '0; m_addr <= '0; m_base <= '0; m_prot <= '0;
         m_pa <= '0; m_en <= '0; m_pend <= 1'b0; m_fault <= 1'b0; m_ns <= 1'b0;
      end else begin
         clr_v = reg_we && reg_addr == 10'h088 && reg_wdata[12];
         flt_v = (m_ph == 2) && mem_rd_valid && !mem_rd_data[1];
         if (reg_we && reg_addr == 10'h000) m_base <= reg_wdata;
         if (reg_we && reg_addr == 10'h085) m_prot <= {reg_wdata[31:7], 7'b0};
         if (reg_we && reg_addr == 10'h088) m_en   <= reg_wdata[7:0];
         case (m_ph)
            0: if (req_valid) begin
               m_ph   <= 1;
               m_iova <= req_iova;
               m_addr <= m_base + {req_iova[31:12], 2'b00};
            end
            1: m_ph <= 2;
            2: if (mem_rd_valid) begin
               m_ph <= 3;
               if (mem_rd_data[1]) begin
                  m_fault <= 1'b0; m_ns <= mem_rd_data[3];
                  m_pa <= {mem_rd_data[31:12], m_iova[11:0]};
               end else begin
                  m_fault <= 1'b1; m_ns <= 1'b0; m_pa <= m_prot;
               end
            end
            default: m_ph <= 0;
         endcase
         if (flt_v && (!m_pend || clr_v)) m_pend <= 1'b1;
         else if (clr_v) m_pend <= 1'b0;
      end
   end

   // Per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(req_ready == (m_ph == 0), "R1 ready", 32'(req_ready), 32'(m_ph == 0));
         chk(mem_rd_en == (m_ph == 1), "R2 fetch strobe", 32'(mem_rd_en), 32'(m_ph == 1));
         if (m_ph == 1) chk(mem_rd_addr == m_addr, "R2 fetch address", mem_rd_addr, m_addr);
         chk(rsp_valid == (m_ph == 3), "R12 response pulse", 32'(rsp_valid), 32'(m_ph == 3));
         if (m_ph == 3) begin
            chk(rsp_fault == m_fault, m_fault ? "R4 fault flag" : "R3 fault flag", 32'(rsp_fault), 32'(m_fault));
            chk(rsp_pa == m_pa, m_fault ? "R4 redirect address" : "R3 physical address", rsp_pa, m_pa);
            chk(rsp_nonsec == m_ns, "R3 non-secure flag", 32'(rsp_nonsec), 32'(m_ns));
         end
         chk(irq == (m_pend && m_en[0]), "R8 irq", 32'(irq), 32'(m_pend && m_en[0]));
      end
   end

   // Descriptor memory responder with a per-request latency
   initial begin
      int          cnt;
      logic [31:0] pend_addr;
      cnt = 0; pend_addr = '0;
      mem_rd_valid = 1'b0; mem_rd_data = '0;
      forever begin
         @(negedge clk);
         mem_rd_valid = 1'b0;
         if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               mem_rd_valid = 1'b1;
               mem_rd_data = dmem.exists(pend_addr) ? dmem[pend_addr] : 32'h0;
            end
         end
         if (mem_rd_en) begin
            cnt = lat_cfg;
            pend_addr = mem_rd_addr;
         end
      end
   end

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
      reg_addr = a;
      #1;
      chk(reg_rdata === exp, tag, reg_rdata, exp);
   endtask

   task automatic send(input logic [31:0] va, input logic [3:0] p, input logic [2:0] ag, input int lat);
      while (!req_ready) @(negedge clk);
      lat_cfg = lat;
      req_valid = 1'b1; req_iova = va; req_port = p; req_agent = ag;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic settle();
      while (!req_ready) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      dmem[32'h0014_8D14] = 32'hABCD_E00A;
      dmem[32'h0010_0004] = 32'h0000_2002;
      dmem[32'h004F_FFFC] = 32'h7777_7002;
      dmem[32'h0012_EB40] = 32'h5555_5008;

      repeat (3) @(negedge clk);
      // R11: reset state
      chk(req_ready == 1'b1, "R11 ready after reset", 32'(req_ready), 32'h1);
      chk(irq == 1'b0, "R11 irq after reset", 32'(irq), 32'h0);
      rd(10'h000, 32'h0, "R11 base reset");
      rd(10'h085, 32'h0, "R11 protect reset");
      rd(10'h088, 32'h0, "R11 int ctl reset");
      rd(10'h089, 32'h0, "R11 status reset");
      rd(10'h08A, 32'h0, "R11 fault va reset");
      rd(10'h0E2, 32'h0, "R11 fault id reset");
      rst_n = 1'b1;
      @(negedge clk);

      wr(10'h000, 32'h0010_0000);
      wr(10'h085, 32'h8000_01FF);
      rd(10'h085, 32'h8000_0180, "R5 protect low bits dropped");
      wr(10'h088, 32'h0000_00FF);
      rd(10'h088, 32'h0000_00FF, "R8 enables read back");

      // R3: valid descriptors under several latencies
      send(32'h1234_5678, 4'd1, 3'd0, 1); settle();
      send(32'h0000_1FFF, 4'd2, 3'd1, 3); settle();
      send(32'hFFFF_F000, 4'd3, 3'd2, 2); settle();
      rd(10'h089, 32'h0, "R3 no fault recorded");

      // R4, R6: first fault is recorded
      send(32'h0BAD_0ABC, 4'd5, 3'd2, 1); settle();
      rd(10'h089, 32'h1, "R6 status bit 0");
      rd(10'h08A, 32'h0BAD_0000, "R6 fault va masked");
      rd(10'h0E2, 32'h0000_8500, "R6 packed id");
      chk(irq == 1'b1, "R8 irq raised", 32'(irq), 32'h1);

      // R7: later fault does not overwrite
      send(32'h012E_B123, 4'd3, 3'd6, 2); settle();
      rd(10'h08A, 32'h0BAD_0000, "R7 va held");
      rd(10'h0E2, 32'h0000_8500, "R7 id held");

      // R9: write without bit 12 keeps record
      wr(10'h088, 32'h0000_00FF);
      rd(10'h089, 32'h1, "R9 no clear without bit 12");

      // R10: clear and new fault in the same cycle
      send(32'h0DDD_0111, 4'd9, 3'd0, 1);
      @(negedge clk);
      wr(10'h088, 32'h0000_10FF);
      settle();
      rd(10'h089, 32'h1, "R10 still pending");
      rd(10'h08A, 32'h0DDD_0000, "R10 new va recorded");
      rd(10'h0E2, 32'h0000_C900, "R10 new id recorded");

      // R9: clear on its own
      wr(10'h088, 32'h0000_10FF);
      rd(10'h089, 32'h0, "R9 cleared");
      rd(10'h088, 32'h0000_00FF, "R9 bit 12 reads zero");
      chk(irq == 1'b0, "R9 irq dropped", 32'(irq), 32'h0);

      // R8: disabled source records without interrupt
      wr(10'h088, 32'h0000_0000);
      send(32'h0777_7000, 4'd15, 3'd6, 2); settle();
      rd(10'h089, 32'h1, "R8 recorded while masked");
      chk(irq == 1'b0, "R8 irq masked", 32'(irq), 32'h0);
      rd(10'h0E2, 32'h0000_0F00, "R6 id agent 6 port 15");
      wr(10'h088, 32'h0000_1001);

      // R2: base change after a walk takes effect on the next one
      wr(10'h000, 32'h0000_0000);
      dmem[32'h0000_0010] = 32'h4444_400A;
      send(32'h0000_4ABC, 4'd0, 3'd0, 1); settle();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end
endmodule